// File: doc/BRIEF.md
# Pulse-Pause Frame Receiver

This block decodes the downlink from a reader to a proximity card. A two-flop synchroniser samples the field input, which is high while the carrier is present and low during a pause. Time is measured in ticks: `tick_en` is asserted once per period of the 212 kHz subcarrier. Each bit is carried by the spacing between the starts of two pauses. A long spacing is a one and a short spacing is a zero. The frame has no end marker. Its end is detected when the spacing goes out of range, which the protocol produces on purpose by holding the carrier after the last pause.

A pulse on `arm` starts a reception. The receiver then waits for the first pause. While it waits, it asks the external keystream generator for one advance when it is armed and one more for every full bit period that passes. Each decoded bit is XORed with the keystream bit present when the bit is decided. The result is placed at the next free position of the frame word, starting at the least significant bit, and one advance is requested after every bit. When the frame ends, the receiver outputs a one-cycle `done` pulse together with the frame word, the bit count, a validity flag and an end-of-frame timestamp. It then waits for the next `arm`.

Top module: `pause_frame_rx`

## Requirements
- R1: During and directly after reset, `done`, `ks_step`, `frame_ok`, `frame_bits`, `frame_len` and `end_stamp` are all zero.
- R2: After an `arm` pulse seen in idle, `ks_step` pulses once. While no pause has been detected, it pulses once more each time 21 further ticks pass. A frame whose first pause is driven m ticks after the arming edge (tick every cycle) has therefore requested 1 + (m+2)/21 advances (integer division) before its first bit.
- R3: If no pause is detected within 41 periods of 21 ticks (861 ticks) after arming, `done` pulses with `frame_ok`=0 and `frame_len`=0. Exactly 41 keystream advances have been requested by then.
- R4: The spacing between two consecutive pause starts, in ticks, decodes as 0 when it is between 4 and 17 inclusive and as 1 when it is between 18 and 31 inclusive.
- R5: Decoded bit i is XORed with `ks_bit` sampled at the decision and is stored at `frame_bits[i]`, so the first bit is the LSB. After every decoded bit, `ks_step` pulses once.
- R6: The frame ends at a code violation. A violation is a spacing of fewer than 4 ticks, or a pause or carrier phase that carries the spacing beyond 31 ticks (a pause arriving at exactly 32 ticks is a violation). The violation itself adds no bit.
- R7: At the end of a frame, `frame_len` is the number of bits decoded, saturating at 31. `frame_ok`=1 exactly when that number is between 6 and 23 inclusive.
- R8: `done` is high for a single cycle. The result outputs keep their values until the next end of frame.
- R9: `end_stamp` equals the tick count at which the most recent accepted pause start was detected, plus 4 (pause length) minus 2 (pipeline compensation). The tick counter starts at 0 at reset and counts every `tick_en`. An accepted pause start is the last pause that decoded a bit, or the violating pause of a short spacing.
- R10: While idle, field activity causes no `done` and no `ks_step`.
- R11: Bits of `frame_bits` at positions at or above `frame_len` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable per subcarrier tick |
| arm | input | 1 | Starts a reception when the block is idle |
| field_in | input | 1 | Asynchronous field level, high = carrier, low = pause |
| ks_bit | input | 1 | Current keystream bit |
| ks_step | output | 1 | One-cycle request to advance the keystream |
| done | output | 1 | One-cycle end-of-frame pulse |
| frame_ok | output | 1 | Frame length inside the legal window |
| frame_bits | output | 24 | Descrambled frame, first bit in bit 0 |
| frame_len | output | 5 | Number of decoded bits |
| end_stamp | output | 16 | Tick timestamp of frame end |

## Verification
The bound checker watches four things on every cycle. It checks that `done` and `ks_step` are single-cycle pulses and never high together. It checks that a flagged-valid result always has a length inside the window and that no frame bit is set above the reported length. It also checks that an idle receiver requests no keystream advance unless it is being armed. Some behaviours can only be shown by the bench's frame sweeps, because they depend on arithmetic over whole scenarios: the spacing thresholds, the descrambled bit order, the exact advance count and timeout distance during the search, and the end timestamp.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

    typedef enum logic [1:0] {
        RX_IDLE    = 2'd0,
        RX_HUNT    = 2'd1,
        RX_PAUSE   = 2'd2,
        RX_CARRIER = 2'd3
    } rx_state_e;

    typedef enum logic [1:0] {
        SYM_ZERO = 2'd0,
        SYM_ONE  = 2'd1,
        SYM_BAD  = 2'd2
    } sym_e;

endpackage

// File: rtl/pfr_edge_sync.sv
module pfr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic fall,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q, chain_d;
    logic              prev_q, prev_d;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end else begin : g_single
            always_comb chain_d = din;
        end
    endgenerate

    always_comb prev_d = chain_q[LAST];

    // Idle line is carrier-present, so reset to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign level = chain_q[LAST];
    assign fall  = prev_q & ~chain_q[LAST];
    assign rise  = ~prev_q & chain_q[LAST];

endmodule

// File: rtl/pfr_tick_stamp.sv
module pfr_tick_stamp #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    output logic [TS_W-1:0] stamp
);
    logic [TS_W-1:0] cnt_q, cnt_d;

    always_comb cnt_d = cnt_q + TS_W'(tick_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign stamp = cnt_q;

endmodule

// File: rtl/pfr_interval_judge.sv
module pfr_interval_judge
    import pfr_pkg::*;
#(
    parameter int CNT_W     = 6,
    parameter int SHORT_TK  = 4,
    parameter int THRESH_TK = 17,
    parameter int LIMIT_TK  = 31
) (
    input  logic [CNT_W-1:0] interval,
    output sym_e             sym,
    output logic             overrun
);
    always_comb begin
        overrun = (interval > CNT_W'(LIMIT_TK));
        if (interval < CNT_W'(SHORT_TK))
            sym = SYM_BAD;
        else if (interval > CNT_W'(THRESH_TK))
            sym = SYM_ONE;
        else
            sym = SYM_ZERO;
    end

endmodule

// File: rtl/pause_frame_rx.sv
module pause_frame_rx
    import pfr_pkg::*;
#(
    parameter int FRAME_W      = 24,
    parameter int LEN_W        = 5,
    parameter int TS_W         = 16,
    parameter int PAUSE_TK     = 4,
    parameter int ONE_TK       = 21,
    parameter int ZERO_TK      = 13,
    parameter int MIN_BITS     = 6,
    parameter int MAX_BITS     = 23,
    parameter int IDLE_PERIODS = 40,
    parameter int COMP_TK      = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               arm,
    input  logic               field_in,
    input  logic               ks_bit,
    output logic               ks_step,
    output logic               done,
    output logic               frame_ok,
    output logic [FRAME_W-1:0] frame_bits,
    output logic [LEN_W-1:0]   frame_len,
    output logic [TS_W-1:0]    end_stamp
);
    localparam int THRESH_TK = (ZERO_TK + ONE_TK) / 2;
    localparam int LIMIT_TK  = (ONE_TK * 3) / 2;
    localparam int CNT_W     = $clog2(LIMIT_TK + 2);
    localparam int HT_W      = $clog2(ONE_TK);
    localparam int PER_W     = $clog2(IDLE_PERIODS + 1);
    localparam logic [LEN_W-1:0] LEN_MAX    = '1;
    localparam logic [TS_W-1:0]  END_OFFSET = TS_W'(PAUSE_TK - COMP_TK);

    typedef struct packed {
        rx_state_e          state;
        logic [HT_W-1:0]    ht;
        logic [PER_W-1:0]   per;
        logic [CNT_W-1:0]   bt;
        logic [LEN_W-1:0]   len;
        logic [FRAME_W-1:0] shreg;
        logic [TS_W-1:0]    pstart;
        logic [FRAME_W-1:0] frame;
        logic [LEN_W-1:0]   flen;
        logic               ok;
        logic [TS_W-1:0]    stamp;
        logic               done;
        logic               step;
    } regs_t;

    regs_t q, d;

    logic            lvl, fall, rise;
    logic [TS_W-1:0] now_ts;
    sym_e            sym;
    logic            overrun;
    logic            finish;
    logic            bit_val;
    logic [CNT_W-1:0] bt_next, bt_restart;

    pfr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (field_in),
        .level (lvl),
        .fall  (fall),
        .rise  (rise)
    );

    pfr_tick_stamp #(.TS_W(TS_W)) u_stamp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .stamp   (now_ts)
    );

    pfr_interval_judge #(
        .CNT_W     (CNT_W),
        .SHORT_TK  (PAUSE_TK),
        .THRESH_TK (THRESH_TK),
        .LIMIT_TK  (LIMIT_TK)
    ) u_judge (
        .interval (q.bt),
        .sym      (sym),
        .overrun  (overrun)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.step     = 1'b0;
        finish     = 1'b0;
        bit_val    = 1'b0;
        bt_next    = overrun ? q.bt : q.bt + CNT_W'(tick_en);
        bt_restart = CNT_W'(tick_en);

        unique case (q.state)
            RX_IDLE: begin
                if (arm) begin
                    d.state = RX_HUNT;
                    d.ht    = '0;
                    d.per   = '0;
                    d.bt    = '0;
                    d.len   = '0;
                    d.shreg = '0;
                    d.step  = 1'b1;
                end
            end

            RX_HUNT: begin
                if (fall && lvl == 1'b0) begin
                    d.state  = RX_PAUSE;
                    d.bt     = bt_restart;
                    d.pstart = now_ts;
                end else if (tick_en) begin
                    if (q.ht == HT_W'(ONE_TK - 1)) begin
                        d.ht = '0;
                        if (q.per == PER_W'(IDLE_PERIODS)) begin
                            finish = 1'b1;
                        end else begin
                            d.per  = q.per + 1'b1;
                            d.step = 1'b1;
                        end
                    end else begin
                        d.ht = q.ht + 1'b1;
                    end
                end
            end

            RX_PAUSE: begin
                if (overrun) begin
                    finish = 1'b1;
                end else begin
                    d.bt = bt_next;
                    if (rise) d.state = RX_CARRIER;
                end
            end

            RX_CARRIER: begin
                if (overrun) begin
                    finish = 1'b1;
                end else if (fall) begin
                    d.pstart = now_ts;
                    d.bt     = bt_restart;
                    if (sym == SYM_BAD) begin
                        finish = 1'b1;
                    end else begin
                        bit_val = (sym == SYM_ONE) ^ ks_bit;
                        for (int k = 0; k < FRAME_W; k++) begin
                            if (q.len == LEN_W'(k)) d.shreg[k] = bit_val;
                        end
                        d.len   = (q.len == LEN_MAX) ? q.len : q.len + 1'b1;
                        d.step  = 1'b1;
                        d.state = RX_PAUSE;
                    end
                end else begin
                    d.bt = bt_next;
                end
            end

            default: d.state = RX_IDLE;
        endcase

        if (finish) begin
            d.state = RX_IDLE;
            d.done  = 1'b1;
            d.frame = q.shreg;
            d.flen  = q.len;
            d.ok    = (q.len >= LEN_W'(MIN_BITS)) && (q.len <= LEN_W'(MAX_BITS));
            d.stamp = d.pstart + END_OFFSET;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ks_step    = q.step;
    assign done       = q.done;
    assign frame_ok   = q.ok;
    assign frame_bits = q.frame;
    assign frame_len  = q.flen;
    assign end_stamp  = q.stamp;

endmodule

// File: rtl/pfr_rx_checker.sv
module pfr_rx_checker #(
    parameter int FRAME_W  = 24,
    parameter int LEN_W    = 5,
    parameter int MIN_BITS = 6,
    parameter int MAX_BITS = 23
) (
    input logic               clk,
    input logic               rst_n,
    input logic               arm,
    input logic               ks_step,
    input logic               done,
    input logic               frame_ok,
    input logic [FRAME_W-1:0] frame_bits,
    input logic [LEN_W-1:0]   frame_len
);
    // R8: the end-of-frame strobe lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2, R5: advance requests are single-cycle pulses
    a_r5_step_single: assert property (@(posedge clk) disable iff (!rst_n)
        ks_step |=> !ks_step);

    // R6: a violation adds no bit, so no advance accompanies the end
    a_r6_no_step_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && ks_step));

    // R7: a valid flag only with a legal length
    a_r7_ok_window: assert property (@(posedge clk) disable iff (!rst_n)
        (done && frame_ok) |-> (frame_len >= LEN_W'(MIN_BITS) && frame_len <= LEN_W'(MAX_BITS)));

    // R11: nothing stored above the reported length
    a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((frame_bits >> frame_len) == '0));

    // R10: once idle, no advance unless armed
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> !ks_step);

endmodule

bind pause_frame_rx pfr_rx_checker #(
    .FRAME_W  (FRAME_W),
    .LEN_W    (LEN_W),
    .MIN_BITS (MIN_BITS),
    .MAX_BITS (MAX_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .ks_step    (ks_step),
    .done       (done),
    .frame_ok   (frame_ok),
    .frame_bits (frame_bits),
    .frame_len  (frame_len)
);

// File: tb/pause_frame_rx_tb.sv
`timescale 1ns/1ps
module pause_frame_rx_tb;

    localparam logic [6:0] SEED = 7'h55;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic        arm = 1'b0;
    logic        field = 1'b1;
    logic        ks_bit;
    logic        ks_clear = 1'b0;
    logic        ks_step, done, frame_ok;
    logic [23:0] frame_bits;
    logic [4:0]  frame_len;
    logic [15:0] end_stamp;

    int n_checks = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    pause_frame_rx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .arm        (arm),
        .field_in   (field),
        .ks_bit     (ks_bit),
        .ks_step    (ks_step),
        .done       (done),
        .frame_ok   (frame_ok),
        .frame_bits (frame_bits),
        .frame_len  (frame_len),
        .end_stamp  (end_stamp)
    );

    // bench keystream source and tick count
    logic [6:0]  lfsr = SEED;
    int          ks_cnt = 0;
    logic [15:0] tb_ts = '0;
    assign ks_bit = lfsr[0];

    always @(posedge clk) begin
        if (rst_n) tb_ts <= tb_ts + 16'd1;
        if (ks_clear) begin
            lfsr   <= SEED;
            ks_cnt <= 0;
        end else if (ks_step) begin
            lfsr   <= {lfsr[5:0], lfsr[6] ^ lfsr[5]};
            ks_cnt <= ks_cnt + 1;
        end
    end

    // end-of-frame monitor
    int          done_seen = 0;
    int          dbl = 0;
    logic        done_prev = 1'b0;
    logic [23:0] cap_frame;
    logic [4:0]  cap_len;
    logic        cap_ok;
    logic [15:0] cap_stamp, cap_ts;
    int          cap_ks;

    always @(negedge clk) begin
        done_prev <= done;
        if (done && done_prev) dbl <= dbl + 1;
        if (done) begin
            done_seen <= done_seen + 1;
            cap_frame <= frame_bits;
            cap_len   <= frame_len;
            cap_ok    <= frame_ok;
            cap_stamp <= end_stamp;
            cap_ts    <= tb_ts;
            cap_ks    <= ks_cnt;
        end
    end

    task automatic check_eq(string tag, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic ks_at(int k);
        logic [6:0] s = SEED;
        for (int j = 0; j < k; j++) s = {s[5:0], s[6] ^ s[5]};
        return s[0];
    endfunction

    task automatic do_arm();
        @(negedge clk); arm = 1'b1; ks_clear = 1'b1;
        @(negedge clk); arm = 1'b0; ks_clear = 1'b0;
    endtask

    task automatic wait_end(int base, int limit);
        int w = 0;
        while (done_seen == base && w < limit) begin
            @(negedge clk);
            w++;
        end
        @(negedge clk);
    endtask

    // tail: 0 carrier timeout, 1 short spacing, 2 long pause, 3 spacing of 32
    task automatic run_frame(int m, int n, logic [31:0] bits, int tail);
        logic [23:0] exp_frame = '0;
        logic [15:0] exp_stamp;
        int h, base;
        base = done_seen;
        do_arm();
        repeat (m) @(negedge clk);
        h = 1 + (m + 2) / 21;
        for (int i = 0; i < n; i++) begin
            int iv;
            iv = bits[i] ? 18 + ((i * 5 + n) % 14) : 4 + ((i * 3 + n) % 14);
            field = 1'b0; exp_stamp = tb_ts + 16'd4;
            repeat (2) @(negedge clk);
            field = 1'b1;
            repeat (iv - 2) @(negedge clk);
        end
        field = 1'b0; exp_stamp = tb_ts + 16'd4;
        case (tail)
            1: begin
                @(negedge clk); field = 1'b1;
                repeat (2) @(negedge clk);
                field = 1'b0; exp_stamp = tb_ts + 16'd4;
                @(negedge clk); field = 1'b1;
            end
            2: begin repeat (45) @(negedge clk); field = 1'b1; end
            3: begin
                repeat (2) @(negedge clk); field = 1'b1;
                repeat (30) @(negedge clk); field = 1'b0;
                repeat (2) @(negedge clk); field = 1'b1;
            end
            default: begin repeat (2) @(negedge clk); field = 1'b1; end
        endcase
        wait_end(base, 400);
        for (int i = 0; i < n && i < 24; i++) exp_frame[i] = bits[i] ^ ks_at(h + i);
        check_eq($sformatf("R6 end detected n=%0d tail=%0d", n, tail), done_seen - base, 1);
        check_eq($sformatf("R4 R5 frame n=%0d tail=%0d", n, tail), cap_frame, exp_frame);
        check_eq($sformatf("R7 len n=%0d", n), cap_len, n);
        check_eq($sformatf("R7 ok n=%0d", n), cap_ok, (n >= 6 && n <= 23));
        check_eq($sformatf("R9 stamp n=%0d tail=%0d", n, tail), cap_stamp, exp_stamp);
        check_eq($sformatf("R2 advances n=%0d m=%0d", n, m), cap_ks, h + n);
        check_eq($sformatf("R11 upper bits n=%0d", n), 64'(cap_frame) >> cap_len, 0);
        repeat (3) @(negedge clk);
        check_eq("R8 done low after pulse", done, 0);
        check_eq("R8 frame held", frame_bits, cap_frame);
        check_eq("R8 stamp held", end_stamp, cap_stamp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check_eq("R1 done at reset", done, 0);
        check_eq("R1 ks_step at reset", ks_step, 0);
        check_eq("R1 frame at reset", frame_bits, 0);
        check_eq("R1 len at reset", frame_len, 0);
        check_eq("R1 ok at reset", frame_ok, 0);
        check_eq("R1 stamp at reset", end_stamp, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R1 done after reset", done, 0);
        check_eq("R1 ks_step after reset", ks_step, 0);

        // R3: no pause after arming
        begin
            int base;
            logic [15:0] ts0;
            base = done_seen;
            do_arm();
            ts0 = tb_ts;
            wait_end(base, 1200);
            check_eq("R3 timeout distance", cap_ts - ts0, 861);
            check_eq("R3 timeout ok", cap_ok, 0);
            check_eq("R3 timeout len", cap_len, 0);
            check_eq("R3 timeout advances", cap_ks, 41);
        end

        // R4 R5 R6 R7 R9 sweep over lengths, delays and end kinds
        for (int n = 0; n <= 25; n++)
            run_frame((n * 47) % 230, n, 32'h9E37_79B1 ^ (n * 32'h0101_2345), n % 4);

        // R2 boundary of the search period
        run_frame(18, 8, 32'h0000_00A5, 0);
        run_frame(19, 8, 32'h0000_005A, 0);
        run_frame(40, 23, 32'h007F_FFFF, 0);
        run_frame(41, 6, 32'h0000_0000, 1);

        // R10: idle field activity is ignored
        begin
            int base;
            logic [23:0] held;
            held = frame_bits;
            @(negedge clk); ks_clear = 1'b1;
            @(negedge clk); ks_clear = 1'b0;
            base = done_seen;
            for (int k = 0; k < 10; k++) begin
                field = 1'b0; repeat (3) @(negedge clk);
                field = 1'b1; repeat (5 + k) @(negedge clk);
            end
            repeat (40) @(negedge clk);
            check_eq("R10 no done while idle", done_seen - base, 0);
            check_eq("R10 no advance while idle", ks_cnt, 0);
            check_eq("R10 result kept while idle", frame_bits, held);
        end

        check_eq("R8 no double done pulses", dbl, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule